// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for one read or write burst inside a single row of a synchronous DRAM. A start strobe loads the starting column together with the burst length code, the ordering (linear or interleaved) and an auto-precharge request. From the next cycle on, the block presents one column per enabled clock until the burst has run its length, is cut short by a stop strobe, or is replaced by a new start.

The clock-enable input is the already registered enable of the surrounding controller. An edge at which it is low changes nothing: the address, the valid and last flags hold, and strobes are ignored. When the command asked for auto precharge, a one-cycle request pulse follows a burst that ran to its natural end, so the row logic can start the self-timed precharge. A full-page burst walks all columns of the row and wraps until it is stopped.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `col_valid`, `last_beat` and `ap_req` are 0 and `col` is 0; `col` reads 0 whenever `col_valid` is 0.
- R2: A `start` sampled at an enabled edge makes `col_valid` 1 and `col` equal to `start_col` in the following cycle, and the burst then advances one beat per enabled edge.
- R3: `burst_code` selects the length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page; codes 4, 5 and 6 behave as length 1. After the final beat `col_valid` falls.
- R4: With `burst_ilv` = 0 and length N, beat k presents the start column with its low log2(N) bits replaced by (low bits + k) mod N; the upper bits stay fixed.
- R5: With `burst_ilv` = 1 and length N of 2, 4 or 8, beat k presents the start column XOR k.
- R6: A full-page burst presents (start + k) mod 256 regardless of `burst_ilv`, wraps past column 255, never asserts `last_beat` and runs until stopped or restarted.
- R7: `last_beat` is 1 exactly on the final beat of a fixed-length burst; a length-1 burst is a single beat with `last_beat` set.
- R8: A `stop` (without `start`) at an enabled edge ends the burst: `col_valid` is 0 in the next cycle and no `ap_req` is produced.
- R9: An edge with `cke` = 0 leaves `col`, `col_valid` and `last_beat` unchanged, ignores `start` and `stop`, and `ap_req` is 0 after it.
- R10: If `auto_pre` was 1 with the start, `ap_req` is 1 for one cycle right after the final beat when that beat is retired by an enabled edge with neither `start` nor `stop`; otherwise it stays 0.
- R11: A `start` during a burst abandons it and restarts from the new column and settings; `start` takes priority over a simultaneous `stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Registered clock enable; 0 freezes the generator |
| start | input | 1 | Start strobe for a new burst |
| start_col | input | 8 | First column of the burst |
| burst_code | input | 3 | Burst length code (see R3) |
| burst_ilv | input | 1 | 1 = interleaved order, 0 = linear |
| auto_pre | input | 1 | Auto precharge requested with the command |
| stop | input | 1 | Burst-stop strobe |
| col | output | 8 | Current column address |
| col_valid | output | 1 | A burst beat is presented on `col` |
| last_beat | output | 1 | Current beat is the final one |
| ap_req | output | 1 | One-cycle auto-precharge request |

## Verification
Linear bursts are started from unaligned columns near the top of their aligned group, so an increment that carries into the upper bits is told apart from a wrap inside the group. Interleaved bursts use start columns with several low bits set, which separates XOR ordering from addition. A full-page run crosses column 255 to show the wrap at the row edge, and stop, restart, simultaneous start-and-stop and clock-enable-low windows placed mid-burst show which event wins and that nothing moves while frozen.

// File: rtl/burst_col_pkg.sv
// Shared types for the burst column address generator.
// Assumes burst lengths are powers of two up to 8, plus a full-page mode.
package burst_col_pkg;
    localparam int LG_W = 2;

    // Settings latched with a start strobe.
    typedef struct packed {
        logic            full;  // full-page burst
        logic            ilv;   // interleaved order requested
        logic            ap;    // auto precharge requested
        logic [LG_W-1:0] lg;    // log2 of the fixed burst length
    } burst_cfg_t;
endpackage

// File: rtl/bcg_cfg_decode.sv
// Turns the raw command-time settings into a burst_cfg_t.
// Assumes length codes 0..3 = 1..8 beats, 7 = full page, others = 1 beat.
module bcg_cfg_decode
    import burst_col_pkg::*;
(
    input  logic [2:0]  burst_code,
    input  logic        burst_ilv,
    input  logic        auto_pre,
    output burst_cfg_t  cfg
);
    // Decode the length code; reserved codes fall back to a single beat.
    always_comb begin
        cfg.ilv  = burst_ilv;
        cfg.ap   = auto_pre;
        cfg.full = (burst_code == 3'd7);
        cfg.lg   = (burst_code[2] == 1'b0) ? burst_code[1:0] : 2'd0;
    end
endmodule

// File: rtl/bcg_addr.sv
// Maps the latched start column and beat index onto the presented column.
// Assumes idx never exceeds the length mask of a fixed-length burst.
module bcg_addr
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             active,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] col,
    output logic             last
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] lin_col;
    logic [COL_W-1:0] ilv_col;

    // One mask bit per column bit: set when that bit wraps inside the burst.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask[i] = cfg.full | (i < int'(cfg.lg));
    end

    // Linear order adds inside the masked field, interleaved order XORs.
    always_comb begin
        lin_col = (base & ~mask) | ((base + idx) & mask);
        ilv_col = base ^ idx;
    end

    // Select the order and blank the column while no burst runs.
    always_comb begin
        if (!active)
            col = '0;
        else if (cfg.ilv && !cfg.full)
            col = ilv_col;
        else
            col = lin_col;
        last = active && !cfg.full && (idx == mask);
    end
endmodule

// File: rtl/bcg_seq.sv
// Burst sequencer: holds the running state and advances one beat per
// enabled edge. Assumes cke is already registered by the caller.
module bcg_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg_in,
    input  logic             stop,
    input  logic             last,
    output logic             active,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] idx,
    output burst_cfg_t       cfg_q,
    output logic             ap_req
);
    // Burst state update: start beats stop, stop beats normal advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= '0;
            idx    <= '0;
            cfg_q  <= '0;
            ap_req <= 1'b0;
        end else if (cke) begin
            ap_req <= active & last & cfg_q.ap & ~start & ~stop;
            if (start) begin
                active <= 1'b1;
                base   <= start_col;
                idx    <= '0;
                cfg_q  <= cfg_in;
            end else if (stop) begin
                active <= 1'b0;
                idx    <= '0;
            end else if (active) begin
                if (last) begin
                    active <= 1'b0;
                    idx    <= '0;
                end else begin
                    idx    <= idx + 1'b1;
                end
            end
        end else begin
            ap_req <= 1'b0;
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
// Top of the burst column address generator: decode, sequencer and
// address mapping. Assumes one row of 2**COL_W columns per burst.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       burst_code,
    input  logic             burst_ilv,
    input  logic             auto_pre,
    input  logic             stop,
    output logic [COL_W-1:0] col,
    output logic             col_valid,
    output logic             last_beat,
    output logic             ap_req
);
    burst_cfg_t       cfg_in;
    burst_cfg_t       cfg_q;
    logic             active;
    logic             last;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] idx;

    bcg_cfg_decode u_dec (
        .burst_code (burst_code),
        .burst_ilv  (burst_ilv),
        .auto_pre   (auto_pre),
        .cfg        (cfg_in)
    );

    bcg_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .start     (start),
        .start_col (start_col),
        .cfg_in    (cfg_in),
        .stop      (stop),
        .last      (last),
        .active    (active),
        .base      (base),
        .idx       (idx),
        .cfg_q     (cfg_q),
        .ap_req    (ap_req)
    );

    bcg_addr #(.COL_W(COL_W)) u_addr (
        .active (active),
        .base   (base),
        .idx    (idx),
        .cfg    (cfg_q),
        .col    (col),
        .last   (last)
    );

    assign col_valid = active;
    assign last_beat = last;
endmodule

// File: rtl/burst_col_gen_chk.sv
// Property checker for burst_col_gen, attached by bind below.
// Assumes synchronous active-low reset.
module burst_col_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic [COL_W-1:0] col,
    input logic             col_valid,
    input logic             last_beat,
    input logic             ap_req
);
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && start) |=> (col_valid && col == $past(start_col))); // R2
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && last_beat && !start) |=> !col_valid); // R3
    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> col_valid); // R7
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && stop && !start) |=> (!col_valid && !ap_req)); // R8
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(col) && $stable(col_valid) && $stable(last_beat) && !ap_req)); // R9
    AST_AP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req |-> $past(last_beat)); // R10
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .start     (start),
    .start_col (start_col),
    .stop      (stop),
    .col       (col),
    .col_valid (col_valid),
    .last_beat (last_beat),
    .ap_req    (ap_req)
);

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes each cycle's expected outputs from
// the requirements and queues them; a monitor compares at the falling edge.
module burst_col_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] burst_code = '0;
    logic       burst_ilv = 1'b0;
    logic       auto_pre = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col;
    logic       col_valid;
    logic       last_beat;
    logic       ap_req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        bit       valid;
        bit [7:0] col;
        bit       last;
        bit       ap;
        string    req;
    } exp_t;
    exp_t exp_q[$];

    // Requirement-level model state.
    bit m_act;
    int m_base, m_idx, m_n;
    bit m_ilv, m_ap;

    always #2.5 clk = ~clk;

    burst_col_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start),
        .start_col(start_col), .burst_code(burst_code),
        .burst_ilv(burst_ilv), .auto_pre(auto_pre), .stop(stop),
        .col(col), .col_valid(col_valid), .last_beat(last_beat),
        .ap_req(ap_req)
    );

    function automatic int len_of(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 0;   // full page
            default: return 1;
        endcase
    endfunction

    function automatic int model_col();
        if (!m_act) return 0;
        if (m_n == 0) return (m_base + m_idx) % 256;
        if (m_ilv) return m_base ^ m_idx;
        return (m_base / m_n) * m_n + ((m_base % m_n) + m_idx) % m_n;
    endfunction

    function automatic bit model_last();
        return m_act && m_n != 0 && m_idx == m_n - 1;
    endfunction

    // Apply one cycle of stimulus and queue the outputs expected after it.
    task automatic step(input bit st, input int sc, input int code, input bit ilv,
                        input bit ap, input bit sp, input bit ce, input string req);
        exp_t e;
        bit nap;
        start = st; start_col = sc[7:0]; burst_code = code[2:0];
        burst_ilv = ilv; auto_pre = ap; stop = sp; cke = ce;
        nap = 1'b0;
        if (ce) begin
            nap = model_last() && m_ap && !st && !sp;
            if (st) begin
                m_act = 1; m_base = sc; m_idx = 0; m_n = len_of(code);
                m_ilv = ilv; m_ap = ap;
            end else if (sp) begin
                m_act = 0; m_idx = 0;
            end else if (m_act) begin
                if (model_last()) begin m_act = 0; m_idx = 0; end
                else m_idx = (m_idx + 1) % 256;
            end
        end
        e.valid = m_act; e.col = model_col(); e.last = model_last();
        e.ap = nap; e.req = req;
        @(posedge clk);
        exp_q.push_back(e);
        #1;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1, req);
    endtask

    // Monitor: compare the design against the oldest queued expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (col_valid !== e.valid || col !== e.col || last_beat !== e.last || ap_req !== e.ap) begin
                n_fail++;
                $display("FAIL %s: got v=%0b col=%02h last=%0b ap=%0b, expected v=%0b col=%02h last=%0b ap=%0b",
                         e.req, col_valid, col, last_beat, ap_req, e.valid, e.col, e.last, e.ap);
            end
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        m_act = 0; m_base = 0; m_idx = 0; m_n = 1; m_ilv = 0; m_ap = 0;
        step(0, 0, 0, 0, 0, 0, 1, "R1 reset");
        step(0, 0, 0, 0, 0, 0, 1, "R1 reset");
        rst_n = 1'b1;
        idle(2, "R1 idle");

        // R7, R3: single beat, and a reserved code acting as length 1
        step(1, 8'h4A, 0, 0, 0, 0, 1, "R7 len1");
        idle(2, "R7 len1 end");
        step(1, 8'h13, 5, 1, 0, 0, 1, "R3 code5");
        idle(2, "R3 code5 end");

        // R2, R4: linear bursts from unaligned columns
        step(1, 8'h05, 1, 0, 0, 0, 1, "R2 lin2");
        idle(3, "R4 lin2");
        step(1, 8'h0E, 2, 0, 0, 0, 1, "R4 lin4");
        idle(5, "R4 lin4");
        step(1, 8'hFB, 3, 0, 0, 0, 1, "R4 lin8");
        idle(9, "R4 lin8");

        // R5: interleaved bursts
        step(1, 8'h35, 3, 1, 0, 0, 1, "R5 ilv8");
        idle(9, "R5 ilv8");
        step(1, 8'hA7, 2, 1, 0, 0, 1, "R5 ilv4");
        idle(5, "R5 ilv4");

        // R6: full page wraps past 255 and keeps going until stopped
        step(1, 8'hFD, 7, 1, 1, 0, 1, "R6 page");
        idle(260, "R6 page");
        step(0, 0, 0, 0, 0, 1, 1, "R8 page stop");
        idle(2, "R8 after stop");

        // R8: stop mid-burst suppresses precharge request
        step(1, 8'h20, 3, 0, 1, 0, 1, "R8 lin8");
        idle(3, "R8 lin8");
        step(0, 0, 0, 0, 0, 1, 1, "R8 stop");
        idle(3, "R8 after stop");

        // R9: clock enable low freezes and ignores strobes
        step(1, 8'h6C, 2, 0, 1, 0, 1, "R9 lin4");
        step(0, 0, 0, 0, 0, 0, 1, "R9 lin4");
        step(1, 8'h99, 3, 1, 0, 0, 0, "R9 frozen start");
        step(0, 0, 0, 0, 0, 1, 0, "R9 frozen stop");
        step(0, 0, 0, 0, 0, 0, 0, "R9 frozen");
        idle(4, "R10 after freeze");

        // R10: precharge request after a natural end, held off by freeze
        step(1, 8'h81, 1, 0, 1, 0, 1, "R10 lin2");
        step(0, 0, 0, 0, 0, 0, 1, "R10 lin2");
        step(0, 0, 0, 0, 0, 0, 0, "R9 frozen last");
        step(0, 0, 0, 0, 0, 0, 1, "R10 ap pulse");
        idle(2, "R10 ap clear");

        // R11: restart mid-burst and start beating stop
        step(1, 8'h40, 3, 0, 1, 0, 1, "R11 first");
        idle(2, "R11 first");
        step(1, 8'hC6, 2, 1, 0, 0, 1, "R11 restart");
        step(0, 0, 0, 0, 0, 0, 1, "R11 restart");
        step(1, 8'h11, 1, 0, 1, 1, 1, "R11 start+stop");
        idle(4, "R11 after");
        // R11: start on the final beat cancels its precharge request
        step(1, 8'h30, 0, 0, 1, 0, 1, "R11 len1 ap");
        step(1, 8'h52, 0, 0, 0, 0, 1, "R11 start at last");
        idle(3, "R11 end");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule